// File: doc/BRIEF.md
# Supply Enable Sequencer

This block switches on a row of regulator enables one after another once the monitored supply is inside its voltage window. It switches them off again in the opposite order when software or a neighbouring controller withdraws the run request. Two status bits describe the supply. One reports that the voltage is above its lower limit and the other reports that it is above its upper limit. Configuration inputs give a start delay and one gap delay for each pair of neighbouring enables. All delays are counted in clock cycles.

Any loss of voltage compliance drops every enable at once, with no ordering. A separate fault flag reports non-compliance on the next clock and releases only after the supply has stayed in range for a programmable deglitch window. A power-on-reset flag holds all enables low. The run request is given as an active-low inhibit, so a tie-off to zero leaves sequencing enabled by default.

Top module: `supply_enable_sequencer`

## Requirements
- R1: While `porActive` is 1, every bit of `enOut` is 0 from the clock edge after it is first sampled. After `rstN` is released, `enOut` reads 0 and `faultOut` reads 1.
- R2: The supply counts as compliant only when `uvOk` is 1 and `ovTrip` is 0. A 0 on `uvOk` and a 1 on `ovTrip` each count as non-compliance.
- R3: In the idle state, the first edge that samples compliance with `seqInhibit` at 0 starts the start delay. `enOut[0]` rises `startDelay`+1 edges after that first edge.
- R4: Enables rise strictly in index order, 0 first. Stage i+1 rises `gapDelay[i]`+1 edges after stage i. `enOut` only ever holds a thermometer code (0000, 0001, 0011, 0111, 1111).
- R5: A gap value of 0 makes the next stage rise exactly one edge after the previous one, never on the same edge.
- R6: Non-compliance during the start delay abandons the start. A later return of compliance begins a complete new start delay.
- R7: Non-compliance in any state clears all enables together on the next edge, whether power-up is in progress or complete.
- R8: When `seqInhibit` rises with all stages on, the start delay runs again. The highest stage then falls after `startDelay`+1 edges. Each lower stage i falls `gapDelay[i]`+1 edges after stage i+1, so stage 2 falls after the gap delay at index 2.
- R9: A rise of `seqInhibit` part way through power-up begins power-down from the highest stage already on. The next stage never turns on. A rise during the start delay returns to idle with nothing on.
- R10: Once power-down has begun, a return of `seqInhibit` to 0 is ignored until every enable is off. The next edge then begins a new start delay.
- R11: `seqInhibit` held at its inactive level 0 is a standing run request.
- R12: `faultOut` is 1 from the edge after non-compliance is sampled. It returns to 0 on the `FLT_CLEAR_CYCLES`-th consecutive edge that samples compliance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porActive | input | 1 | Power-on-reset flag; holds all enables low |
| uvOk | input | 1 | 1 when the supply is above its lower limit |
| ovTrip | input | 1 | 1 when the supply is above its upper limit |
| seqInhibit | input | 1 | Active-high stop request; 0 requests the powered-up state |
| startDelay | input | DW | Cycle count of the start delay, used for power-up and power-down |
| gapDelay | input | (STAGES-1)×DW | Packed gap counts; index i sets the gap between stage i and stage i+1 |
| enOut | output | STAGES | Regulator enables; bit 0 is first on and last off |
| faultOut | output | 1 | Debounced non-compliance flag |

## Verification
Power-up is exercised from several starting points: release of the power-on-reset flag, recovery after an over-voltage pulse, recovery after a lower-limit dip, and a restart queued during power-down. Matching timing across these runs shows that the start delay does not depend on how idle was reached. A zero gap between the middle stages tells a one-cycle minimum apart from a same-edge rise. A compliance dip inside the start delay tells a restarted timer apart from a resumed one. Withdrawing the request after two stages, and again inside the start delay, tells a power-down that starts from the current level apart from one that always starts at the top stage.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_UP,
    ST_STEP_UP,
    ST_FULL,
    ST_PRE_DN,
    ST_STEP_DN
  } seq_state_e;

  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic clearAll;   // drop every enable, zero the timer
    logic loadStart;  // load the timer with the start delay
    logic loadGap;    // load the timer with the gap for the next step
    logic stepUp;     // one more stage on
    logic stepDown;   // one stage fewer on
  } seq_strobe_t;

endpackage

// File: rtl/seq_fault_filter.sv
module seq_fault_filter #(
  parameter int FLT_CLEAR_CYCLES = 7500
) (
  input  logic clk,
  input  logic rstN,
  input  logic compliant,
  output logic faultOut
);
  localparam int CW = (FLT_CLEAR_CYCLES < 2) ? 1 : $clog2(FLT_CLEAR_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FLT_CLEAR_CYCLES - 1);

  logic [CW-1:0] goodCnt;
  logic          faultQ;

  // set at once, release only after a run of compliant samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
      faultQ  <= 1'b1;
    end else if (!compliant) begin
      goodCnt <= '0;
      faultQ  <= 1'b1;
    end else if (goodCnt == LAST) begin
      faultQ  <= 1'b0;
    end else begin
      goodCnt <= goodCnt + 1'b1;
    end
  end

  assign faultOut = faultQ;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int LW     = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porActive,
  input  logic        compliant,
  input  logic        runReq,
  input  logic        cntZero,
  input  logic [LW-1:0] level,
  output seq_strobe_t stb
);
  localparam logic [LW-1:0] TOP_IDX = LW'(STAGES - 1);
  localparam logic [LW-1:0] ONE     = LW'(1);

  seq_state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    if (porActive || !compliant) begin
      stb.clearAll = 1'b1;
      stateD       = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (runReq) begin
            stb.loadStart = 1'b1;
            stateD        = ST_PRE_UP;
          end
        end
        ST_PRE_UP: begin
          if (!runReq) begin
            stb.clearAll = 1'b1;
            stateD       = ST_IDLE;
          end else if (cntZero) begin
            stb.stepUp = 1'b1;
            if (level == TOP_IDX) begin
              stateD = ST_FULL;
            end else begin
              stb.loadGap = 1'b1;
              stateD      = ST_STEP_UP;
            end
          end
        end
        ST_STEP_UP: begin
          if (!runReq) begin
            stb.loadStart = 1'b1;
            stateD        = ST_PRE_DN;
          end else if (cntZero) begin
            stb.stepUp = 1'b1;
            if (level == TOP_IDX) begin
              stateD = ST_FULL;
            end else begin
              stb.loadGap = 1'b1;
            end
          end
        end
        ST_FULL: begin
          if (!runReq) begin
            stb.loadStart = 1'b1;
            stateD        = ST_PRE_DN;
          end
        end
        ST_PRE_DN, ST_STEP_DN: begin
          // the request is not looked at until everything is off
          if (cntZero) begin
            stb.stepDown = 1'b1;
            if (level == ONE) begin
              stateD = ST_IDLE;
            end else begin
              stb.loadGap = 1'b1;
              stateD      = ST_STEP_DN;
            end
          end
        end
        default: begin
          stb.clearAll = 1'b1;
          stateD       = ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int DW     = 16,
  parameter int LW     = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seq_strobe_t                   stb,
  input  logic [DW-1:0]                 startDelay,
  input  logic [STAGES-2:0][DW-1:0]     gapDelay,
  output logic                          cntZero,
  output logic [LW-1:0]                 level,
  output logic [STAGES-1:0]             enOut
);
  logic [DW-1:0] cntQ;
  logic [LW-1:0] levelQ;
  logic [DW-1:0] gapSel;

  // stepping up from level i waits gap i; stepping down to level i waits gap i-1
  always_comb begin
    gapSel = '0;
    for (int i = 0; i < STAGES - 1; i++) begin
      if (stb.stepUp   && levelQ == LW'(i))     gapSel = gapDelay[i];
      if (stb.stepDown && levelQ == LW'(i + 2)) gapSel = gapDelay[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      levelQ <= '0;
    end else if (stb.clearAll) begin
      cntQ   <= '0;
      levelQ <= '0;
    end else begin
      if (stb.stepUp)        levelQ <= levelQ + 1'b1;
      else if (stb.stepDown) levelQ <= levelQ - 1'b1;

      if (stb.loadStart)     cntQ <= startDelay;
      else if (stb.loadGap)  cntQ <= gapSel;
      else if (cntQ != '0)   cntQ <= cntQ - 1'b1;
    end
  end

  assign cntZero = (cntQ == '0);
  assign level   = levelQ;

  for (genvar g = 0; g < STAGES; g++) begin : g_en
    assign enOut[g] = (levelQ > LW'(g));
  end

endmodule

// File: rtl/supply_enable_sequencer.sv
module supply_enable_sequencer
  import seq_pkg::*;
#(
  parameter int STAGES           = 4,
  parameter int DW               = 16,
  parameter int FLT_CLEAR_CYCLES = 7500
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      porActive,
  input  logic                      uvOk,
  input  logic                      ovTrip,
  input  logic                      seqInhibit,
  input  logic [DW-1:0]             startDelay,
  input  logic [STAGES-2:0][DW-1:0] gapDelay,
  output logic [STAGES-1:0]         enOut,
  output logic                      faultOut
);
  localparam int LW = $clog2(STAGES + 1);

  logic          compliant;
  logic          runReq;
  logic          cntZero;
  logic [LW-1:0] level;
  seq_strobe_t   stb;

  assign compliant = uvOk & ~ovTrip;
  assign runReq    = ~seqInhibit;

  seq_ctrl #(.STAGES(STAGES), .LW(LW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .porActive (porActive),
    .compliant (compliant),
    .runReq    (runReq),
    .cntZero   (cntZero),
    .level     (level),
    .stb       (stb)
  );

  seq_datapath #(.STAGES(STAGES), .DW(DW), .LW(LW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .startDelay (startDelay),
    .gapDelay   (gapDelay),
    .cntZero    (cntZero),
    .level      (level),
    .enOut      (enOut)
  );

  seq_fault_filter #(.FLT_CLEAR_CYCLES(FLT_CLEAR_CYCLES)) u_flt (
    .clk       (clk),
    .rstN      (rstN),
    .compliant (compliant),
    .faultOut  (faultOut)
  );

endmodule

// File: rtl/supply_enable_sequencer_chk.sv
module supply_enable_sequencer_chk #(
  parameter int STAGES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              porActive,
  input logic              uvOk,
  input logic              ovTrip,
  input logic              seqInhibit,
  input logic [STAGES-1:0] enOut,
  input logic              faultOut
);

  // R1: reset flag forces everything off
  p_por_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    porActive |=> (enOut == '0));

  // R7 and R2: any non-compliance clears all enables together
  p_drop_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!uvOk || ovTrip) |=> (enOut == '0));

  // R12: fault flag follows non-compliance on the next edge
  p_fault_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!uvOk || ovTrip) |=> faultOut);

  // R3: first stage only rises from a compliant, requested sample
  p_start_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enOut[0]) |-> $past(uvOk && !ovTrip && !seqInhibit && !porActive));

  // R4: enables stay a thermometer code
  p_thermo_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((enOut & (enOut + 1'b1)) == '0));

  // R4 and R8: ordered changes move one stage at a time
  p_one_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((enOut != '0) && !$stable(enOut)) |-> ($countones(enOut ^ $past(enOut)) == 1));

endmodule

bind supply_enable_sequencer supply_enable_sequencer_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .porActive  (porActive),
  .uvOk       (uvOk),
  .ovTrip     (ovTrip),
  .seqInhibit (seqInhibit),
  .enOut      (enOut),
  .faultOut   (faultOut)
);

// File: tb/sim_supply_enable_sequencer.sv
module sim_supply_enable_sequencer;
  localparam int STAGES = 4;
  localparam int DW     = 8;
  localparam int CLR    = 40;
  localparam int S      = 5;
  localparam int G [3]  = '{3, 0, 7};

  logic clk = 1'b0;
  logic rstN, por, uv, ov, inh;
  logic [DW-1:0] startDelay;
  logic [STAGES-2:0][DW-1:0] gapDelay;
  logic [STAGES-1:0] enOut;
  logic faultOut;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  typedef struct {
    int          cyc;
    logic [3:0]  en;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  supply_enable_sequencer #(.STAGES(STAGES), .DW(DW), .FLT_CLEAR_CYCLES(CLR)) u0 (
    .clk(clk), .rstN(rstN), .porActive(por), .uvOk(uv), .ovTrip(ov),
    .seqInhibit(inh), .startDelay(startDelay), .gapDelay(gapDelay),
    .enOut(enOut), .faultOut(faultOut)
  );

  function automatic logic [3:0] therm(int l);
    return 4'((1 << l) - 1);
  endfunction

  function automatic void push(int c, logic [3:0] e, string tag);
    exp_t it;
    it.cyc = c; it.en = e; it.tag = tag;
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > c) begin
        q.insert(i, it);
        return;
      end
    end
    q.push_back(it);
  endfunction

  // monitor: compare the enables against the scoreboard away from the edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      nChecks++;
      if (e.cyc != cyc || enOut !== e.en) begin
        nFails++;
        $display("FAIL %s cycle %0d: enOut=%b expected %b (due cycle %0d)",
                 e.tag, cyc, enOut, e.en, e.cyc);
      end
    end
  end

  task automatic check(logic act, logic expv, string tag);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, act, expv);
    end
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // R3 R4 R5: expected power-up from the first sampling edge b
  task automatic expUp(int b, output int tEnd);
    int t;
    t = b + S + 1;
    push(t - 1, 4'b0000, "R3");
    push(t, 4'b0001, "R3");
    for (int l = 1; l < STAGES; l++) begin
      t += G[l-1] + 1;
      push(t - 1, therm(l), (l == 2) ? "R5" : "R4");
      push(t, therm(l + 1), (l == 2) ? "R5" : "R4");
    end
    tEnd = t;
  endtask

  // R8: expected power-down from level L, first sampling edge b
  task automatic expDown(int b, int L, output int tEnd);
    int t;
    t = b + S + 1;
    push(t - 1, therm(L), "R8");
    push(t, therm(L - 1), "R8");
    for (int l = L - 1; l >= 1; l--) begin
      t += G[l-1] + 1;
      push(t - 1, therm(l), "R8");
      push(t, therm(l - 1), "R8");
    end
    tEnd = t;
  endtask

  initial begin
    int b, d, m, t, t2, tA, tB;
    rstN = 1'b0; por = 1'b1; uv = 1'b0; ov = 1'b0; inh = 1'b1;
    startDelay = DW'(S);
    gapDelay = {DW'(G[2]), DW'(G[1]), DW'(G[0])};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(enOut == 4'b0, 1'b1, "R1 reset enables");
    check(faultOut, 1'b1, "R12 reset fault");

    // R1 R11: compliant and requested, but reset flag still active
    uv = 1'b1; inh = 1'b0;
    repeat (6) @(negedge clk);
    check(enOut == 4'b0, 1'b1, "R1 por hold");
    por = 1'b0;
    b = cyc + 1;
    expUp(b, t);
    waitUntil(t + 1);

    // R2 R7 R12: one-cycle over-voltage pulse with all stages on
    ov = 1'b1;
    m = cyc + 1;
    push(m, 4'b0000, "R7");
    @(negedge clk);
    ov = 1'b0;
    check(faultOut, 1'b1, "R12 fault set");
    expUp(m + 1, t);
    waitUntil(m + CLR - 1);
    check(faultOut, 1'b1, "R12 fault still held");
    @(negedge clk);
    check(faultOut, 1'b0, "R12 fault released");
    waitUntil(t + 1);

    // R8: reverse power-down
    inh = 1'b1;
    d = cyc + 1;
    expDown(d, 4, t);
    waitUntil(t + 1);

    // R6: dip inside the start delay restarts the full delay
    inh = 1'b0;
    b = cyc + 1;
    waitUntil(b + 1);
    uv = 1'b0;
    push(b + 2, 4'b0000, "R6");
    @(negedge clk);
    uv = 1'b1;
    push(b + S + 1, 4'b0000, "R6");
    expUp(b + 3, t);
    waitUntil(t + 1);

    inh = 1'b1;
    d = cyc + 1;
    expDown(d, 4, t);
    waitUntil(t + 1);

    // R9: withdrawal after two stages powers down from stage 1
    inh = 1'b0;
    b = cyc + 1;
    tA = b + S + 1;
    tB = tA + G[0] + 1;
    push(tA - 1, 4'b0000, "R9");
    push(tA, 4'b0001, "R9");
    push(tB - 1, 4'b0001, "R9");
    push(tB, 4'b0011, "R9");
    waitUntil(tB);
    inh = 1'b1;
    d = cyc + 1;
    push(d + 1, 4'b0011, "R9");
    expDown(d, 2, t);
    waitUntil(t + 1);

    // R9: withdrawal inside the start delay returns to idle
    inh = 1'b0;
    b = cyc + 1;
    waitUntil(b + 1);
    inh = 1'b1;
    push(b + S + 1, 4'b0000, "R9");
    push(b + S + 3, 4'b0000, "R9");
    waitUntil(b + S + 4);

    // R10: request returns mid power-down
    inh = 1'b0;
    b = cyc + 1;
    expUp(b, t);
    waitUntil(t + 1);
    inh = 1'b1;
    d = cyc + 1;
    expDown(d, 4, t2);
    waitUntil(d + S + 3);
    inh = 1'b0;
    push(t2, 4'b0000, "R10");
    expUp(t2 + 1, t);
    waitUntil(t + 1);

    // R2 R7: lower-limit dip with all stages on
    uv = 1'b0;
    m = cyc + 1;
    push(m, 4'b0000, "R2");
    push(m + 2, 4'b0000, "R7");
    waitUntil(m);
    check(faultOut, 1'b1, "R2 fault on low supply");
    waitUntil(m + 2);
    uv = 1'b1;
    b = cyc + 1;
    expUp(b, t);
    waitUntil(t + 1);

    // R1: reset flag with all stages on
    por = 1'b1;
    m = cyc + 1;
    push(m, 4'b0000, "R1");
    push(m + 1, 4'b0000, "R1");
    push(m + 2, 4'b0000, "R1");
    waitUntil(m + 2);
    por = 1'b0;
    b = cyc + 1;
    expUp(b, t);
    waitUntil(t + 2);

    if (q.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard: %0d expectations left", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule